// File: doc/BRIEF.md
# Big-Endian Byte-Lane Load/Store Unit

This unit connects a processor core to a data memory that is one 32-bit word wide and answers reads one cycle after the request. The core supplies a byte address that has already been computed, an access size (a full word or a single byte), a direction (load or store), and the store operand. The unit produces the word index for the memory port, a four-bit byte-write-enable mask, and write data with each byte placed in the correct lane. It also returns the aligned load result one cycle later.

Bytes are numbered big-endian by default. The lowest byte address in a word selects the most significant lane, bits [31:24]. A parameter switches to little-endian numbering so that both mappings can be compared side by side. A word access whose address is not a multiple of four is reported and has no effect on memory. A byte load is sign-extended to 32 bits.

Top module: `lsu_be`

## Requirements
- R1: `mem_addr` always equals `req_addr[ADDR_W-1:2]`, and it is combinational in the same cycle as the request.
- R2: An aligned word store (`req_word`=1, `req_addr[1:0]`=0) drives `mem_we`=4'b1111 and `mem_wdata`=`req_wdata`.
- R3: A word access with `req_addr[1:0]`≠0 raises `misalign` in that cycle. It drives `mem_we`=0 and `mem_re`=0, and `ld_valid` stays low in the following cycle.
- R4: A byte store drives exactly one bit of `mem_we`, bit index 3−`req_addr[1:0]` when big-endian. `mem_wdata` carries `req_wdata[7:0]` in all four byte positions.
- R5: A load of either size drives `mem_we`=0 and raises `mem_re` unless it is misaligned. Idle cycles drive `mem_we`=0 and `mem_re`=0.
- R6: One cycle after an accepted byte load, `ld_valid`=1. `ld_data[7:0]` is the byte of `mem_rdata` in lane k (bits [8k+7:8k]), where k is the lane chosen at request time, and bits [31:8] repeat bit 7 of that byte.
- R7: One cycle after an accepted word load, `ld_valid`=1 and `ld_data`=`mem_rdata` unchanged.
- R8: With `BIG_ENDIAN`=0, byte offset k selects lane k, both for the write-enable bit and for the load byte.
- R9: While `rst_n` is low and right after reset, `ld_valid` is 0.
- R10: A byte access never raises `misalign`, whatever its offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_addr | input | ADDR_W | Byte effective address |
| req_wdata | input | 32 | Store operand |
| mem_addr | output | ADDR_W-2 | Word index to memory |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 4 | Per-lane write enable, bit k covers bits [8k+7:8k] |
| mem_wdata | output | 32 | Lane-positioned write data |
| mem_rdata | input | 32 | Read word, valid the cycle after `mem_re` |
| misalign | output | 1 | Misaligned word access flag |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Aligned, extended load result |

## Verification
A load result comes back in the cycle after its request. At that moment the core may already be presenting the next access, which can be a store, a misaligned word access, or another load. The bench runs the full sweep back to back, so every return of a load result shares its cycle with a new request, and it feeds a fresh `mem_rdata` pattern on each step. In each such cycle it checks the returned data against the offset and size registered one cycle earlier. In the same cycle it checks the write mask, write data and misalign flag of the new request against values computed from the current inputs. This shows that the registered load state and the request decode do not interfere.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
    localparam int LSU_DW    = 32;
    localparam int LSU_LANES = LSU_DW / 8;
    localparam int LSU_OFF_W = $clog2(LSU_LANES);

    typedef struct packed {
        logic                 vld;
        logic                 word;
        logic [LSU_OFF_W-1:0] lane;
    } lsu_pend_t;
endpackage

// File: rtl/lsu_lane_map.sv
module lsu_lane_map
    import lsu_pkg::*;
#(
    parameter bit BIG_ENDIAN = 1'b1
) (
    input  logic [LSU_OFF_W-1:0] byte_off,
    output logic [LSU_OFF_W-1:0] lane
);
    generate
        if (BIG_ENDIAN) begin : g_big
            assign lane = LSU_OFF_W'(LSU_LANES - 1) - byte_off;
        end else begin : g_little
            assign lane = byte_off;
        end
    endgenerate
endmodule

// File: rtl/lsu_store_path.sv
module lsu_store_path
    import lsu_pkg::*;
(
    input  logic                 wr_ok,
    input  logic                 is_word,
    input  logic [LSU_OFF_W-1:0] lane,
    input  logic [LSU_DW-1:0]    st_data,
    output logic [LSU_LANES-1:0] we,
    output logic [LSU_DW-1:0]    wdata
);
    for (genvar k = 0; k < LSU_LANES; k++) begin : g_lane
        assign we[k]          = wr_ok & (is_word | (lane == LSU_OFF_W'(k)));
        assign wdata[k*8 +: 8] = is_word ? st_data[k*8 +: 8] : st_data[7:0];
    end
endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align
    import lsu_pkg::*;
(
    input  logic                 is_word,
    input  logic [LSU_OFF_W-1:0] lane,
    input  logic [LSU_DW-1:0]    rdata,
    output logic [LSU_DW-1:0]    data
);
    logic [7:0] bytes [LSU_LANES];
    logic [7:0] sel;

    for (genvar k = 0; k < LSU_LANES; k++) begin : g_split
        assign bytes[k] = rdata[k*8 +: 8];
    end

    always_comb begin
        sel  = bytes[lane];
        data = is_word ? rdata : {{(LSU_DW-8){sel[7]}}, sel};
    end
endmodule

// File: rtl/lsu_be.sv
module lsu_be
    import lsu_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter bit BIG_ENDIAN = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_store,
    input  logic                   req_word,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [LSU_DW-1:0]      req_wdata,
    output logic [ADDR_W-LSU_OFF_W-1:0] mem_addr,
    output logic                   mem_re,
    output logic [LSU_LANES-1:0]   mem_we,
    output logic [LSU_DW-1:0]      mem_wdata,
    input  logic [LSU_DW-1:0]      mem_rdata,
    output logic                   misalign,
    output logic                   ld_valid,
    output logic [LSU_DW-1:0]      ld_data
);
    logic [LSU_OFF_W-1:0] off;
    logic [LSU_OFF_W-1:0] req_lane;
    logic                 wr_ok;
    lsu_pend_t            pend_d, pend_q;

    assign off      = req_addr[LSU_OFF_W-1:0];
    assign mem_addr = req_addr[ADDR_W-1:LSU_OFF_W];
    assign misalign = req_valid & req_word & (off != '0);
    assign wr_ok    = req_valid & req_store & ~misalign;
    assign mem_re   = req_valid & ~req_store & ~misalign;

    lsu_lane_map #(.BIG_ENDIAN(BIG_ENDIAN)) u_map (
        .byte_off (off),
        .lane     (req_lane)
    );

    lsu_store_path u_st (
        .wr_ok   (wr_ok),
        .is_word (req_word),
        .lane    (req_lane),
        .st_data (req_wdata),
        .we      (mem_we),
        .wdata   (mem_wdata)
    );

    always_comb begin
        pend_d      = pend_q;
        pend_d.vld  = mem_re;
        pend_d.word = req_word;
        pend_d.lane = req_lane;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    lsu_load_align u_ld (
        .is_word (pend_q.word),
        .lane    (pend_q.lane),
        .rdata   (mem_rdata),
        .data    (ld_data)
    );

    assign ld_valid = pend_q.vld;

    AST_MISALIGN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (mem_we == '0 && !mem_re)); // R3
    AST_MISALIGN_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |=> !ld_valid); // R3
    AST_BYTE_STORE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && !req_word) |-> $countones(mem_we) == 1); // R4
    AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_store) |-> mem_we == '0); // R5
    AST_RESULT_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(mem_re)); // R6
    AST_BYTE_NEVER_MISALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_word) |-> !misalign); // R10
    AST_WORD_STORE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && req_word && !misalign) |-> mem_we == '1); // R2
endmodule

// File: tb/lsu_be_tb.sv
module lsu_be_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        req_valid = 0, req_store = 0, req_word = 0;
    logic [31:0] req_addr = 0, req_wdata = 0, mem_rdata = 0;

    logic [29:0] be_addr, le_addr;
    logic        be_re, le_re, be_mis, le_mis, be_lv, le_lv;
    logic [3:0]  be_we, le_we;
    logic [31:0] be_wd, le_wd, be_ld, le_ld;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    lsu_be #(.ADDR_W(32), .BIG_ENDIAN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
        .mem_addr(be_addr), .mem_re(be_re), .mem_we(be_we), .mem_wdata(be_wd),
        .mem_rdata(mem_rdata), .misalign(be_mis), .ld_valid(be_lv), .ld_data(be_ld));

    lsu_be #(.ADDR_W(32), .BIG_ENDIAN(1'b0)) u_dut_le (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
        .mem_addr(le_addr), .mem_re(le_re), .mem_we(le_we), .mem_wdata(le_wd),
        .mem_rdata(mem_rdata), .misalign(le_mis), .ld_valid(le_lv), .ld_data(le_ld));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_ld(input logic [31:0] rd, input bit word, input int lane);
        logic [7:0] b;
        b = rd[lane*8 +: 8];
        return word ? rd : {{24{b[7]}}, b};
    endfunction

    // state of the previous request, for the response cycle
    bit pv_load = 0, pv_word = 0;
    int pv_off = 0;

    task automatic step(input bit v, input bit st, input bit w, input logic [31:0] a,
                        input logic [31:0] wd, input logic [31:0] rd);
        int off;
        bit mis, acc;
        logic [3:0] web, wel;
        logic [31:0] wdx;
        @(negedge clk);
        req_valid = v; req_store = st; req_word = w; req_addr = a;
        req_wdata = wd; mem_rdata = rd;
        #1;
        off = int'(a[1:0]);
        mis = v && w && (off != 0);
        acc = v && !mis;
        web = (acc && st) ? (w ? 4'hF : 4'(1 << (3 - off))) : 4'h0;
        wel = (acc && st) ? (w ? 4'hF : 4'(1 << off)) : 4'h0;
        wdx = w ? wd : {4{wd[7:0]}};
        chk(be_addr == a[31:2], "R1 word index", {2'b0, be_addr}, {2'b0, a[31:2]});
        chk(be_mis == mis, (w ? "R3 misalign flag" : "R10 byte never misaligned"), 32'(be_mis), 32'(mis));
        chk(be_we == web, (!st ? "R5 load no write" : (w ? "R2/R3 word mask" : "R4 byte lane mask")),
            32'(be_we), 32'(web));
        chk(le_we == wel, "R8 little-endian mask", 32'(le_we), 32'(wel));
        chk(be_re == (acc && !st), "R5 read strobe", 32'(be_re), 32'(acc && !st));
        if (acc && st)
            chk(be_wd == wdx, (w ? "R2 word data" : "R4 byte replicated"), be_wd, wdx);
        chk(be_lv == pv_load, "R6/R7/R3 result valid", 32'(be_lv), 32'(pv_load));
        if (pv_load) begin
            chk(be_ld == exp_ld(rd, pv_word, 3 - pv_off), (pv_word ? "R7 word load" : "R6 byte load"),
                be_ld, exp_ld(rd, pv_word, 3 - pv_off));
            chk(le_ld == exp_ld(rd, pv_word, pv_off), "R8 little-endian load",
                le_ld, exp_ld(rd, pv_word, pv_off));
        end
        pv_load = acc && !st;
        pv_word = w;
        pv_off  = off;
    endtask

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'h807F_C315; pats[1] = 32'h15C3_7F80;
        pats[2] = 32'hA5_01_FF_7E; pats[3] = 32'h7E_FF_01_A5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(be_lv == 0 && le_lv == 0, "R9 reset result valid", 32'(be_lv), 32'h0);
        chk(be_we == 0, "R5 idle no write", 32'(be_we), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(be_lv == 0, "R9 after reset", 32'(be_lv), 32'h0);
        for (int p = 0; p < 4; p++)
            for (int sz = 0; sz < 2; sz++)
                for (int dir = 0; dir < 2; dir++)
                    for (int o = 0; o < 4; o++)
                        step(1'b1, dir[0], sz[0], 32'h0000_1230 + 32'(p * 64) + 32'(o),
                             pats[p] ^ 32'(o * 32'h0101_0101), pats[(p + o) % 4]);
        step(1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 32'hC0DE_0080);
        step(1'b0, 1'b0, 1'b0, 32'h4, 32'h0, 32'h0);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule